// File: doc/BRIEF.md
# Hierarchical Frame Scan Address Generator

This block walks a planar 8-bit YCbCr frame store in the nested order used by a block-based, motion-compensated video coder, and emits one linear memory address per accepted cycle. The frame is tiled into groups of macroblocks. Each group is 11 macroblocks wide by 3 macroblocks tall. Each macroblock carries four 8x8 luma blocks followed by one Cb block and one Cr block. Two frame sizes are supported: a full size of 352x288 luma samples with 12 groups, and a quarter size of 176x144 with 3 groups. The chroma planes are subsampled by two in both directions.

A single `start_i` pulse latches the format select and the three plane base addresses, then starts the walk. Addresses leave through a valid/ready stream: an address is taken on every rising edge where `valid_o` and `ready_i` are both high. While `ready_i` is low, the address, indices, plane tag and flags hold their values and `valid_o` stays high. `valid_o` never drops in the middle of a frame. Alongside each address the block reports:
- the plane tag;
- the group, macroblock and block indices;
- four end-of-unit flags, which mark the last address of a block, a macroblock, a group and the frame.

The block that consumes the addresses uses the flags to frame its own work.

Top module: `vid_scan_addr_gen`

## Requirements
- R1: After reset `valid_o` and every flag are low, and they stay low with no start. A `start_i` pulse seen while idle makes `valid_o` high on the next cycle. The first address is the Y base (row 0, column 0 of block 0 of macroblock 0 of group 0).
- R2: Inside a block, samples are visited row by row and left to right. The address steps by 1 along a row. From one row to the next it steps by the line stride, which is 352 (full) or 176 (quarter) for luma.
- R3: `blk_o` counts 0..5 inside a macroblock. Blocks 0,1,2,3 are the luma blocks at top-left, top-right, bottom-left and bottom-right; block 1 starts 8 samples right of block 0. Block 4 is Cb and block 5 is Cr. `plane_o` is 0 for Y, 1 for Cb and 2 for Cr.
- R4: `mb_o` counts 0..32 in raster order over a group that is 11 macroblocks wide and 3 tall, with `mb_o` = row*11 + column.
- R5: In the full format `gob_o` runs 0..11. The groups tile the frame two across and six down in raster order: even indices on the left, odd on the right, and group 1 starts 176 samples right of group 0. In the quarter format `gob_o` runs 0..2, stacked vertically.
- R6: A chroma sample address is its plane base plus row times half the luma stride plus column. Chroma coordinates are the luma coordinates halved, so the first Cb address is the Cb base.
- R7: While `valid_o` is high and `ready_i` is low, `valid_o` and all data outputs hold. With `ready_i` high, one address is taken per cycle, with no gap.
- R8: `eob_o` is high with the last address of each block. `eomb_o` is high with the last address of block 5. `eogob_o` is high with the last address of macroblock 32. `eof_o` is high with the last address of the last group.
- R9: A frame yields exactly 152064 (full) or 38016 (quarter) transfers. `valid_o` is low on the cycle after the transfer that carries `eof_o`.
- R10: The format and base inputs are latched only on an accepted start. A `start_i` pulse during a scan, or a change of those inputs during a scan, has no effect on the output sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| fmt_full_i | input | 1 | 1 = full size, 0 = quarter size; latched on start |
| base_y_i | input | AW (24) | Luma plane base address |
| base_cb_i | input | AW (24) | Cb plane base address |
| base_cr_i | input | AW (24) | Cr plane base address |
| ready_i | input | 1 | Downstream ready |
| valid_o | output | 1 | Address valid |
| addr_o | output | AW (24) | Linear sample address |
| plane_o | output | 2 | 0 = Y, 1 = Cb, 2 = Cr |
| gob_o | output | 4 | Group index, 0-based |
| mb_o | output | 6 | Macroblock index within the group, 0-based |
| blk_o | output | 3 | Block index within the macroblock, 0..5 |
| eob_o | output | 1 | Last address of a block |
| eomb_o | output | 1 | Last address of a macroblock |
| eogob_o | output | 1 | Last address of a group |
| eof_o | output | 1 | Last address of the frame |

## Verification
The first address and `valid_o` are due one edge after the start pulse is sampled. Every later output reflects the counters one edge after a transfer. The bench drives inputs and samples outputs on the falling edge, so a value read there is the result of the most recent rising edge. It compares each transfer against a scan model that it steps only when `valid_o` and `ready_i` are both high. During a stall it checks, one edge later, that the outputs are unchanged. `valid_o` must be low one edge after the `eof_o` transfer. The bench sets the block dimension to 4 to shorten each frame, and its model computes every address and total from that dimension.

// File: rtl/vsa_pkg.sv
package vsa_pkg;
  typedef enum logic [1:0] {
    PL_Y  = 2'd0,
    PL_CB = 2'd1,
    PL_CR = 2'd2
  } plane_e;
endpackage

// File: rtl/vsa_wrap_cnt.sv
// One level of the nested scan: counts 0..last_i, wraps on increment at last.
module vsa_wrap_cnt #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] last_i,
  output logic [W-1:0] cnt_o,
  output logic         at_last_o,
  output logic         wrap_o
);
  assign at_last_o = (cnt_o == last_i);
  assign wrap_o    = inc_i & at_last_o;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (inc_i)  cnt_o <= at_last_o ? '0 : cnt_o + 1'b1;
  end

  // R4 (index ranges for every level, including block and group)
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o <= last_i);
endmodule

// File: rtl/vsa_addr_map.sv
// Maps the scan position to a plane, tile coordinates and a linear address.
module vsa_addr_map
  import vsa_pkg::*;
#(
  parameter int AW      = 24,
  parameter int BLK_DIM = 8,
  parameter int MB_COLS = 11,
  parameter int MB_ROWS = 3,
  parameter int BLK_W   = 3,
  parameter int MBX_W   = 4,
  parameter int MBY_W   = 2,
  parameter int GOB_W   = 4
) (
  input  logic              fmt_full_i,
  input  logic [AW-1:0]     base_y_i,
  input  logic [AW-1:0]     base_cb_i,
  input  logic [AW-1:0]     base_cr_i,
  input  logic [BLK_W-1:0]  col_i,
  input  logic [BLK_W-1:0]  row_i,
  input  logic [2:0]        blk_i,
  input  logic [MBX_W-1:0]  mbx_i,
  input  logic [MBY_W-1:0]  mby_i,
  input  logic [GOB_W-1:0]  gob_i,
  output logic [AW-1:0]     addr_o,
  output logic [1:0]        plane_o
);
  localparam int MB_DIM    = 2 * BLK_DIM;
  localparam int GRP_W     = MB_COLS * MB_DIM;
  localparam int GRP_H     = MB_ROWS * MB_DIM;
  localparam int LINE_FULL = 2 * GRP_W;

  logic [AW-1:0] gx, gy, stride_y, px, py;
  plane_e        plane;

  always_comb begin
    gx       = fmt_full_i ? AW'(gob_i[0]) : '0;
    gy       = fmt_full_i ? AW'(gob_i >> 1) : AW'(gob_i);
    stride_y = fmt_full_i ? AW'(LINE_FULL) : AW'(LINE_FULL / 2);
    if (blk_i < 3'd4) begin
      px     = gx * AW'(GRP_W) + AW'(mbx_i) * AW'(MB_DIM)
             + (blk_i[0] ? AW'(BLK_DIM) : '0) + AW'(col_i);
      py     = gy * AW'(GRP_H) + AW'(mby_i) * AW'(MB_DIM)
             + (blk_i[1] ? AW'(BLK_DIM) : '0) + AW'(row_i);
      plane  = PL_Y;
      addr_o = base_y_i + py * stride_y + px;
    end else begin
      px     = gx * AW'(GRP_W / 2) + AW'(mbx_i) * AW'(BLK_DIM) + AW'(col_i);
      py     = gy * AW'(GRP_H / 2) + AW'(mby_i) * AW'(BLK_DIM) + AW'(row_i);
      plane  = (blk_i == 3'd4) ? PL_CB : PL_CR;
      addr_o = ((blk_i == 3'd4) ? base_cb_i : base_cr_i)
             + py * (stride_y >> 1) + px;
    end
    plane_o = plane;
  end
endmodule

// File: rtl/vid_scan_addr_gen.sv
module vid_scan_addr_gen #(
  parameter int AW      = 24,
  parameter int BLK_DIM = 8,
  parameter int MB_COLS = 11,
  parameter int MB_ROWS = 3
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 start_i,
  input  logic                                 fmt_full_i,
  input  logic [AW-1:0]                        base_y_i,
  input  logic [AW-1:0]                        base_cb_i,
  input  logic [AW-1:0]                        base_cr_i,
  input  logic                                 ready_i,
  output logic                                 valid_o,
  output logic [AW-1:0]                        addr_o,
  output logic [1:0]                           plane_o,
  output logic [3:0]                           gob_o,
  output logic [$clog2(MB_COLS*MB_ROWS)-1:0]   mb_o,
  output logic [2:0]                           blk_o,
  output logic                                 eob_o,
  output logic                                 eomb_o,
  output logic                                 eogob_o,
  output logic                                 eof_o
);
  localparam int BLK_W      = (BLK_DIM > 1) ? $clog2(BLK_DIM) : 1;
  localparam int MBX_W      = $clog2(MB_COLS);
  localparam int MBY_W      = (MB_ROWS > 1) ? $clog2(MB_ROWS) : 1;
  localparam int MBI_W      = $clog2(MB_COLS * MB_ROWS);
  localparam int GOB_W      = 4;
  localparam int GOBS_FULL  = 12;
  localparam int GOBS_QTR   = 3;
  localparam int BLKS_PER_MB = 6;

  logic          run_q, fmt_q;
  logic [AW-1:0] base_y_q, base_cb_q, base_cr_q;
  logic          start_ok, xfer;

  logic [BLK_W-1:0] col, row;
  logic [2:0]       blk;
  logic [MBX_W-1:0] mbx;
  logic [MBY_W-1:0] mby;
  logic [GOB_W-1:0] gob, gob_last;
  logic col_last, row_last, blk_last, mbx_last, mby_last, gob_last_hit;
  logic w_col, w_row, w_blk, w_mbx, w_mby, w_gob;

  assign start_ok = start_i & ~run_q;
  assign xfer     = run_q & ready_i;
  assign gob_last = fmt_q ? GOB_W'(GOBS_FULL - 1) : GOB_W'(GOBS_QTR - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      fmt_q     <= 1'b0;
      base_y_q  <= '0;
      base_cb_q <= '0;
      base_cr_q <= '0;
    end else if (start_ok) begin
      run_q     <= 1'b1;
      fmt_q     <= fmt_full_i;
      base_y_q  <= base_y_i;
      base_cb_q <= base_cb_i;
      base_cr_q <= base_cr_i;
    end else if (w_gob) begin
      run_q     <= 1'b0;
    end
  end

  // Nested counters, innermost first: column, row, block, mb column, mb row, group.
  vsa_wrap_cnt #(.W(BLK_W)) u_col (.clk(clk), .rst_n(rst_n), .clr_i(start_ok),
    .inc_i(xfer), .last_i(BLK_W'(BLK_DIM - 1)), .cnt_o(col), .at_last_o(col_last), .wrap_o(w_col));
  vsa_wrap_cnt #(.W(BLK_W)) u_row (.clk(clk), .rst_n(rst_n), .clr_i(start_ok),
    .inc_i(w_col), .last_i(BLK_W'(BLK_DIM - 1)), .cnt_o(row), .at_last_o(row_last), .wrap_o(w_row));
  vsa_wrap_cnt #(.W(3)) u_blk (.clk(clk), .rst_n(rst_n), .clr_i(start_ok),
    .inc_i(w_row), .last_i(3'(BLKS_PER_MB - 1)), .cnt_o(blk), .at_last_o(blk_last), .wrap_o(w_blk));
  vsa_wrap_cnt #(.W(MBX_W)) u_mbx (.clk(clk), .rst_n(rst_n), .clr_i(start_ok),
    .inc_i(w_blk), .last_i(MBX_W'(MB_COLS - 1)), .cnt_o(mbx), .at_last_o(mbx_last), .wrap_o(w_mbx));
  vsa_wrap_cnt #(.W(MBY_W)) u_mby (.clk(clk), .rst_n(rst_n), .clr_i(start_ok),
    .inc_i(w_mbx), .last_i(MBY_W'(MB_ROWS - 1)), .cnt_o(mby), .at_last_o(mby_last), .wrap_o(w_mby));
  vsa_wrap_cnt #(.W(GOB_W)) u_gob (.clk(clk), .rst_n(rst_n), .clr_i(start_ok),
    .inc_i(w_mby), .last_i(gob_last), .cnt_o(gob), .at_last_o(gob_last_hit), .wrap_o(w_gob));

  vsa_addr_map #(
    .AW(AW), .BLK_DIM(BLK_DIM), .MB_COLS(MB_COLS), .MB_ROWS(MB_ROWS),
    .BLK_W(BLK_W), .MBX_W(MBX_W), .MBY_W(MBY_W), .GOB_W(GOB_W)
  ) u_map (
    .fmt_full_i(fmt_q), .base_y_i(base_y_q), .base_cb_i(base_cb_q), .base_cr_i(base_cr_q),
    .col_i(col), .row_i(row), .blk_i(blk), .mbx_i(mbx), .mby_i(mby), .gob_i(gob),
    .addr_o(addr_o), .plane_o(plane_o)
  );

  assign valid_o = run_q;
  assign gob_o   = gob;
  assign blk_o   = blk;
  assign mb_o    = MBI_W'(mby) * MBI_W'(MB_COLS) + MBI_W'(mbx);
  assign eob_o   = run_q & col_last & row_last;
  assign eomb_o  = eob_o & blk_last;
  assign eogob_o = eomb_o & mbx_last & mby_last;
  assign eof_o   = eogob_o & gob_last_hit;

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !ready_i |=> valid_o && $stable(addr_o) && $stable(blk_o)
                            && $stable(mb_o) && $stable(gob_o) && $stable(plane_o));
  // R9
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && ready_i && eof_o |=> !valid_o);
  // R7
  no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && ready_i && !eof_o |=> valid_o);
  // R2
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && ready_i && !col_last |=> addr_o == $past(addr_o) + AW'(1));
  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && start_i |=> $stable(fmt_q) && $stable(base_y_q)
                           && $stable(base_cb_q) && $stable(base_cr_q));
endmodule

// File: tb/vid_scan_addr_gen_bench.sv
module vid_scan_addr_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 24;
  localparam int B   = 4;
  localparam int MBC = 11;
  localparam int MBR = 3;
  localparam int LW_FULL = 2 * MBC * 2 * B;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic rst_n, start_i, fmt_full_i, ready_i;
  logic [AW-1:0] base_y_i, base_cb_i, base_cr_i;
  logic valid_o, eob_o, eomb_o, eogob_o, eof_o;
  logic [AW-1:0] addr_o;
  logic [1:0] plane_o;
  logic [3:0] gob_o;
  logic [5:0] mb_o;
  logic [2:0] blk_o;

  vid_scan_addr_gen #(.AW(AW), .BLK_DIM(B), .MB_COLS(MBC), .MB_ROWS(MBR)) u_vid_scan_addr_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .fmt_full_i(fmt_full_i),
    .base_y_i(base_y_i), .base_cb_i(base_cb_i), .base_cr_i(base_cr_i), .ready_i(ready_i),
    .valid_o(valid_o), .addr_o(addr_o), .plane_o(plane_o), .gob_o(gob_o), .mb_o(mb_o),
    .blk_o(blk_o), .eob_o(eob_o), .eomb_o(eomb_o), .eogob_o(eogob_o), .eof_o(eof_o));

  int checks = 0, failures = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Scan model
  int e_col, e_row, e_blk, e_mbx, e_mby, e_gob, e_by, e_bcb, e_bcr;
  bit e_full;

  function automatic int n_gob();
    return e_full ? 12 : 3;
  endfunction

  function automatic int exp_addr();
    int gx, gy, sy, x, y;
    gx = e_full ? (e_gob % 2) : 0;
    gy = e_full ? (e_gob / 2) : e_gob;
    sy = e_full ? LW_FULL : LW_FULL / 2;
    if (e_blk < 4) begin
      x = gx * MBC * 2 * B + e_mbx * 2 * B + (e_blk % 2) * B + e_col;
      y = gy * MBR * 2 * B + e_mby * 2 * B + (e_blk / 2) * B + e_row;
      return e_by + y * sy + x;
    end
    x = gx * MBC * B + e_mbx * B + e_col;
    y = gy * MBR * B + e_mby * B + e_row;
    return ((e_blk == 4) ? e_bcb : e_bcr) + y * (sy / 2) + x;
  endfunction

  function automatic bit x_eob();   return e_col == B - 1 && e_row == B - 1; endfunction
  function automatic bit x_eomb();  return x_eob() && e_blk == 5; endfunction
  function automatic bit x_eogob(); return x_eomb() && e_mbx == MBC - 1 && e_mby == MBR - 1; endfunction
  function automatic bit x_eof();   return x_eogob() && e_gob == n_gob() - 1; endfunction

  task automatic model_step();
    if (e_col < B - 1) begin e_col++; return; end
    e_col = 0;
    if (e_row < B - 1) begin e_row++; return; end
    e_row = 0;
    if (e_blk < 5) begin e_blk++; return; end
    e_blk = 0;
    if (e_mbx < MBC - 1) begin e_mbx++; return; end
    e_mbx = 0;
    if (e_mby < MBR - 1) begin e_mby++; return; end
    e_mby = 0;
    e_gob++;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start_i = 1'b0; ready_i = 1'b1; fmt_full_i = 1'b0;
    base_y_i = '0; base_cb_i = '0; base_cr_i = '0;
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0, "R1 valid low in reset", valid_o, 0);
    check(eof_o == 1'b0 && eob_o == 1'b0, "R1 flags low in reset", eof_o, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(valid_o == 1'b0, "R1 idle without start", valid_o, 0);
  endtask

  // mode 0: ready always high; 1: one stall in three; 2: bursts of six stalls
  task automatic t_scan(input bit full, input int by, input int bcb, input int bcr,
                        input int mode, input bit inject, input string name);
    int m_addr = 0, m_plane = 0, m_idx = 0, m_flag = 0, m_hold = 0, m_gap = 0;
    int n = 0, cyc = 0, total;
    int first_b1 = -1, first_g1 = -1, first_cb = -1, want_g1;
    bit done = 0, prev_stall = 0;
    logic [AW-1:0] s_addr; logic [2:0] s_blk; logic [5:0] s_mb; logic [3:0] s_gob;
    total = (full ? LW_FULL * LW_FULL * 9 / 11 / 11 : LW_FULL * LW_FULL * 9 / 11 / 11 / 4);
    total = (full ? (2 * MBC * 2 * B) * (6 * MBR * 2 * B) : (MBC * 2 * B) * (3 * MBR * 2 * B)) * 3 / 2;
    e_col = 0; e_row = 0; e_blk = 0; e_mbx = 0; e_mby = 0; e_gob = 0;
    e_full = full; e_by = by; e_bcb = bcb; e_bcr = bcr;
    @(negedge clk);
    fmt_full_i = full; base_y_i = AW'(by); base_cb_i = AW'(bcb); base_cr_i = AW'(bcr);
    start_i = 1'b1; ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    check(valid_o == 1'b1, {"R1 valid one cycle after start ", name}, valid_o, 1);
    check(int'(addr_o) == by, {"R1 first address ", name}, addr_o, by);
    if (inject) begin
      fmt_full_i = ~full; base_y_i = AW'(by + 777); base_cb_i = AW'(bcb + 5); base_cr_i = AW'(bcr + 9);
    end
    while (!done && cyc < 60000) begin
      cyc++;
      case (mode)
        0: ready_i = 1'b1;
        1: ready_i = (cyc % 3) != 0;
        default: ready_i = (cyc % 17) > 5;
      endcase
      start_i = inject && (cyc == 40 || cyc == 41 || cyc == 3000);
      if (prev_stall && (addr_o != s_addr || blk_o != s_blk || mb_o != s_mb
                         || gob_o != s_gob || valid_o != 1'b1)) m_hold++;
      prev_stall = valid_o && !ready_i;
      s_addr = addr_o; s_blk = blk_o; s_mb = mb_o; s_gob = gob_o;
      if (!valid_o) m_gap++;
      else if (ready_i) begin
        if (int'(addr_o) != exp_addr()) begin
          if (m_addr == 0) $display("  mismatch %s n=%0d addr=%0d want=%0d", name, n, addr_o, exp_addr());
          m_addr++;
        end
        if (int'(plane_o) != ((e_blk < 4) ? 0 : e_blk - 3)) m_plane++;
        if (int'(gob_o) != e_gob || int'(mb_o) != e_mby * MBC + e_mbx || int'(blk_o) != e_blk) m_idx++;
        if (eob_o != x_eob() || eomb_o != x_eomb() || eogob_o != x_eogob() || eof_o != x_eof()) m_flag++;
        if (first_b1 < 0 && blk_o == 3'd1) first_b1 = int'(addr_o);
        if (first_cb < 0 && blk_o == 3'd4) first_cb = int'(addr_o);
        if (first_g1 < 0 && gob_o == 4'd1) first_g1 = int'(addr_o);
        n++;
        if (x_eof()) done = 1;
        model_step();
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    check(valid_o == 1'b0, {"R9 valid low after last transfer ", name}, valid_o, 0);
    check(n == total, {"R9 transfer count ", name}, n, total);
    check(m_addr == 0, {"R2 R5 R6 address sequence ", name}, m_addr, 0);
    check(m_plane == 0, {"R3 plane tags ", name}, m_plane, 0);
    check(m_idx == 0, {"R4 R5 indices ", name}, m_idx, 0);
    check(m_flag == 0, {"R8 boundary flags ", name}, m_flag, 0);
    check(m_hold == 0, {"R7 hold during stall ", name}, m_hold, 0);
    check(m_gap == 0, {"R7 no valid gap ", name}, m_gap, 0);
    check(first_b1 == by + B, {"R3 block 1 origin ", name}, first_b1, by + B);
    check(first_cb == bcb, {"R6 first Cb address ", name}, first_cb, bcb);
    want_g1 = full ? by + MBC * 2 * B : by + MBR * 2 * B * (LW_FULL / 2);
    check(first_g1 == want_g1, {"R5 group 1 origin ", name}, first_g1, want_g1);
    if (inject)
      check(m_addr == 0 && n == total, {"R10 mid-scan start and input change ignored ", name}, n, total);
  endtask

  initial begin
    t_reset();
    t_scan(1'b0, 1000, 200000, 300000, 1, 1'b0, "quarter/stall");
    t_scan(1'b1, 5000, 400000, 600000, 0, 1'b0, "full/stream");
    t_scan(1'b0, 7000, 100000, 150000, 2, 1'b1, "quarter/restart");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule